// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire, open-drain bus in the SMBus style. It gives a bus controller read and write access to a small bank of 8-bit configuration registers. Each register loads a known default on reset, so the surrounding logic works without any serial access. The register contents are presented continuously on a flat parallel output for the rest of the chip.

The controller first sends the 8-bit address byte 0xD2, which is 7-bit address 0x69 followed by a zero direction bit. It then sends a command byte. That byte picks single-register access or sequential block access and, for single access, carries the register index. Block writes carry a length byte ahead of the data. Block reads return a length byte produced by the slave, followed by the registers from index 0 upward. A repeated START followed by 0xD3 turns the transfer around for a read.

Both bus lines are oversampled by the system clock through a short synchronizer. The slave never drives SCL. It pulls SDA low through `sda_oe` to acknowledge a byte or to send a 0 bit.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register i (for i = 0 to NREG-1) holds DEF_BASE + i, so with the defaults regs_o byte i is 0xA0 + i, and sda_oe is 0.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read). Any other address is not acknowledged, and every following byte up to the next START is neither acknowledged nor acted on.
- R3: A command byte whose bits 6:5 are not 00 is not acknowledged, and the transaction has no effect up to the next START.
- R4: A byte write is START, 0xD2, a command with bit 7 = 1 and the index in bits 4:0, one data byte, then STOP. It acknowledges every byte and updates only the indexed register. The update takes place at the SCL fall that opens the acknowledge of the data byte.
- R5: A byte read is START, 0xD2, a command with bit 7 = 1 and the index, repeated START, then 0xD3. It returns the indexed register, most significant bit first.
- R6: A block write is START, 0xD2, command 0x00, a length byte N, then N data bytes. The data bytes go to registers 0, 1, 2 and so on, in that order, and each byte is acknowledged.
- R7: A STOP after any complete data byte of a block write leaves the earlier bytes written and the later registers unchanged.
- R8: In a block write, a data byte beyond the length N is not acknowledged and is not written.
- R9: A block read is START, 0xD2, command 0x00, repeated START, then 0xD3. It returns first the byte NREG (8), then registers 0 upward. It stops driving SDA after the controller does not acknowledge a byte.
- R10: A register index of NREG or above reads as 0x00, and a write to it changes no register.
- R11: sda_oe changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| regs_o | output | NREG*8 | Register file; byte i is register i |

## Verification
A bus edge reaches the control logic about three system clocks after the pin changes: two synchronizer stages and one edge register. The SDA drive therefore changes about four clocks after an SCL fall. The bench holds every SCL phase for ten clocks. It samples an acknowledge or a read bit after SCL has been high for a full phase, and it changes its own SDA level only while SCL is low. Register writes are checked after the STOP, many clocks after the commit. A monitor sampled on the falling clock edge records any change of sda_oe while SCL is high.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_IGN
    } smb_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_WDATA
    } smb_ph_e;

    typedef struct packed {
        smb_st_e     st;
        smb_ph_e     ph;
        logic [7:0]  sh;
        logic [3:0]  bitcnt;
        logic [7:0]  ptr;
        logic [7:0]  remain;
        logic        blk;
        logic        cntf;
        logic        rd;
        logic        cmd_ok;
        logic        mack;
    } smb_fsm_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic rise_ev,
    output logic fall_ev,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic              scl_p_d, scl_p_q, sda_p_d, sda_p_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign scl_d[i] = scl_i;
                assign sda_d[i] = sda_i;
            end else begin : g_next
                assign scl_d[i] = scl_q[i-1];
                assign sda_d[i] = sda_q[i-1];
            end
        end
    endgenerate

    assign scl_s   = scl_q[STAGES-1];
    assign sda_s   = sda_q[STAGES-1];
    assign scl_p_d = scl_s;
    assign sda_p_d = sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_q   <= scl_d;
            sda_q   <= sda_d;
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end

    assign rise_ev  = scl_s & ~scl_p_q;
    assign fall_ev  = ~scl_s & scl_p_q;
    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int         NREG     = 8,
    parameter logic [7:0] DEF_BASE = 8'hA0,
    localparam int        IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [7:0]        wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] regs_o
);
    logic [NREG-1:0][7:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en && (int'(waddr) < NREG)) begin
            reg_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                reg_q[i] <= DEF_BASE + 8'(i);
            end
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rdata  = (int'(raddr) < NREG) ? reg_q[raddr] : 8'h00;
    assign regs_o = reg_q;
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NREG        = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] DEF_BASE    = 8'hA0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam int         IDX_W    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] CNT_BYTE = 8'(NREG);

    logic scl_s, sda_s, rise_ev, fall_ev, start_ev, stop_ev;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_fsm_t   r_d, r_q;
    logic       wr_en;
    logic [7:0] bank_rdata, rd_byte, tx_byte;
    logic       in_range;

    smb_reg_bank #(.NREG(NREG), .DEF_BASE(DEF_BASE)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .waddr  (r_q.ptr[IDX_W-1:0]),
        .wdata  (r_q.sh),
        .raddr  (r_q.ptr[IDX_W-1:0]),
        .rdata  (bank_rdata),
        .regs_o (regs_o)
    );

    assign in_range = (int'(r_q.ptr) < NREG);
    assign rd_byte  = in_range ? bank_rdata : 8'h00;
    assign tx_byte  = (r_q.blk && r_q.cntf) ? CNT_BYTE : rd_byte;

    always_comb begin
        r_d   = r_q;
        wr_en = 1'b0;
        if (stop_ev) begin
            r_d.st     = ST_IDLE;
            r_d.cmd_ok = 1'b0;
        end else if (start_ev) begin
            r_d.st     = ST_RX;
            r_d.ph     = PH_ADDR;
            r_d.bitcnt = 4'd0;
            r_d.rd     = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (rise_ev && r_q.bitcnt < 4'd8) begin
                        r_d.sh     = {r_q.sh[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (fall_ev && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = 4'd0;
                        r_d.st     = ST_IGN;
                        case (r_q.ph)
                            PH_ADDR: begin
                                if (r_q.sh[7:1] == DEV_ADDR) begin
                                    if (!r_q.sh[0]) begin
                                        r_d.st = ST_RACK;
                                        r_d.ph = PH_CMD;
                                    end else if (r_q.cmd_ok) begin
                                        r_d.st = ST_RACK;
                                        r_d.rd = 1'b1;
                                    end
                                end
                            end
                            PH_CMD: begin
                                if (r_q.sh[6:5] == 2'b00) begin
                                    r_d.st     = ST_RACK;
                                    r_d.cmd_ok = 1'b1;
                                    r_d.blk    = ~r_q.sh[7];
                                    r_d.cntf   = ~r_q.sh[7];
                                    r_d.ptr    = r_q.sh[7] ? {3'b000, r_q.sh[4:0]} : 8'h00;
                                    r_d.remain = r_q.sh[7] ? 8'd1 : 8'd0;
                                    r_d.ph     = r_q.sh[7] ? PH_WDATA : PH_CNT;
                                end
                            end
                            PH_CNT: begin
                                r_d.st     = ST_RACK;
                                r_d.remain = r_q.sh;
                                r_d.ph     = PH_WDATA;
                            end
                            default: begin
                                if (r_q.remain != 8'd0) begin
                                    r_d.st     = ST_RACK;
                                    wr_en      = in_range;
                                    r_d.remain = r_q.remain - 8'd1;
                                    if (r_q.ptr != 8'hFF) begin
                                        r_d.ptr = r_q.ptr + 8'd1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (fall_ev) begin
                        if (r_q.rd) begin
                            r_d.st     = ST_TX;
                            r_d.sh     = tx_byte;
                            r_d.bitcnt = 4'd0;
                            if (r_q.blk && r_q.cntf) begin
                                r_d.cntf = 1'b0;
                            end else if (r_q.ptr != 8'hFF) begin
                                r_d.ptr = r_q.ptr + 8'd1;
                            end
                        end else begin
                            r_d.st     = ST_RX;
                            r_d.bitcnt = 4'd0;
                        end
                    end
                end
                ST_TX: begin
                    if (rise_ev && r_q.bitcnt < 4'd8) begin
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (fall_ev) begin
                        if (r_q.bitcnt == 4'd8) begin
                            r_d.st   = ST_TACK;
                            r_d.mack = 1'b0;
                        end else if (r_q.bitcnt != 4'd0) begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                        end
                    end
                end
                ST_TACK: begin
                    if (rise_ev) begin
                        r_d.mack = ~sda_s;
                    end else if (fall_ev) begin
                        if (r_q.mack) begin
                            r_d.st     = ST_TX;
                            r_d.sh     = tx_byte;
                            r_d.bitcnt = 4'd0;
                            if (r_q.blk && r_q.cntf) begin
                                r_d.cntf = 1'b0;
                            end else if (r_q.ptr != 8'hFF) begin
                                r_d.ptr = r_q.ptr + 8'd1;
                            end
                        end else begin
                            r_d.st = ST_IGN;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: PH_ADDR, sh: 8'h00, bitcnt: 4'd0,
                     ptr: 8'h00, remain: 8'h00, blk: 1'b0, cntf: 1'b0,
                     rd: 1'b0, cmd_ok: 1'b0, mack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = (r_q.st == ST_RACK) || ((r_q.st == ST_TX) && !r_q.sh[7]);

    smb_st_e    st_q;
    logic [3:0] bitcnt_q;
    logic [7:0] ptr_q;
    assign st_q     = r_q.st;
    assign bitcnt_q = r_q.bitcnt;
    assign ptr_q    = r_q.ptr;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              fall_ev,
    input smb_st_e           st_q,
    input logic [3:0]        bitcnt_q,
    input logic [7:0]        ptr_q,
    input logic [NREG*8-1:0] regs_o
);
    // R11
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R2
    start_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q == ST_RX && bitcnt_q == 4'd0));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st_q == ST_IDLE && !sda_oe));

    // R4
    reg_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> $past(fall_ev));

    // R10
    reg_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o != $past(regs_o)) |-> (int'($past(ptr_q)) < NREG));

    // R6
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= 4'd8);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .fall_ev  (fall_ev),
    .st_q     (st_q),
    .bitcnt_q (bitcnt_q),
    .ptr_q    (ptr_q),
    .regs_o   (regs_o)
);

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;
    localparam int NREG = 8;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] regs_o;

    int n_chk = 0;
    int n_bad = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] exp_reg [NREG];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_cfg_slave u_smb_cfg_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    // R11 monitor: sda_oe may not change while SCL is high
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe != oe_prev)) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0;
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        ack = ~sda_line;
        scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl_m = 1'b1; w(Q); b[i] = sda_line; scl_m = 1'b0;
        end
        w(2); sda_m = ~give_ack; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0;
        w(2); sda_m = 1'b1; w(Q);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NREG; i++) chk(req, regs_o[i*8 +: 8], exp_reg[i]);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'hA0 + 8'(i);
        chk_regs("R1 reset default");
        chk("R1 sda_oe idle", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_byte_write();
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk("R2 addr ack", {7'd0, a}, 8'h01);
        send_byte(8'h83, a); chk("R4 cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h5C, a); chk("R4 data ack", {7'd0, a}, 8'h01);
        bus_stop();
        exp_reg[3] = 8'h5C;
        chk_regs("R4 byte write");
    endtask

    task automatic t_byte_read();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h83, a);
        bus_start();
        send_byte(8'hD3, a); chk("R5 read addr ack", {7'd0, a}, 8'h01);
        recv_byte(1'b0, b); chk("R5 byte read", b, exp_reg[3]);
        bus_stop();
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h86, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, b); chk("R5 byte read idx6", b, exp_reg[6]);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hA4, a); chk("R2 foreign addr nack", {7'd0, a}, 8'h00);
        send_byte(8'h83, a); chk("R2 ignored cmd nack", {7'd0, a}, 8'h00);
        send_byte(8'h11, a); chk("R2 ignored data nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk_regs("R2 no write after foreign addr");
    endtask

    task automatic t_bad_cs();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'hA3, a); chk("R3 chip select nack", {7'd0, a}, 8'h00);
        send_byte(8'h22, a); chk("R3 data ignored", {7'd0, a}, 8'h00);
        bus_stop();
        chk_regs("R3 no write");
    endtask

    task automatic t_block_write();
        logic a;
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a); chk("R6 block cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h04, a); chk("R6 count ack", {7'd0, a}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            send_byte(d[i], a); chk("R6 data ack", {7'd0, a}, 8'h01);
            exp_reg[i] = d[i];
        end
        bus_stop();
        chk_regs("R6 block write");
    endtask

    task automatic t_early_stop();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        send_byte(8'h91, a);
        send_byte(8'h92, a);
        bus_stop();
        exp_reg[0] = 8'h91;
        exp_reg[1] = 8'h92;
        chk_regs("R7 early stop");
    endtask

    task automatic t_over_count();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h71, a); chk("R8 in-count ack", {7'd0, a}, 8'h01);
        send_byte(8'h72, a); chk("R8 over-count nack", {7'd0, a}, 8'h00);
        bus_stop();
        exp_reg[0] = 8'h71;
        chk_regs("R8 over count");
    endtask

    task automatic t_block_read();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b1, b); chk("R9 length byte", b, 8'(NREG));
        for (int i = 0; i < NREG; i++) begin
            recv_byte(i != NREG - 1, b);
            chk("R9 block data", b, exp_reg[i]);
        end
        chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
        bus_stop();
    endtask

    task automatic t_out_of_range();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h8A, a);
        send_byte(8'hEE, a);
        bus_stop();
        chk_regs("R10 write ignored");
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h8A, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, b); chk("R10 reads zero", b, 8'h00);
        bus_stop();
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(5);
        t_reset();
        t_byte_write();
        t_byte_read();
        t_bad_addr();
        t_bad_cs();
        t_block_write();
        t_early_stop();
        t_over_count();
        t_block_read();
        t_out_of_range();
        chk("R11 no sda change with SCL high", 8'(oe_viol), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule